// File: doc/BRIEF.md
# Main-CPU Interrupt and Keyboard Port Controller

This block is the small register bank that sits between an 8-bit main processor and the events it must answer: key presses, the break key, a periodic timer, a printer, external sound and pointer chips, and a companion sub-processor. It folds the maskable sources into one IRQ line and the urgent sources into one FIRQ line. It exposes six byte-wide offsets on a simple select/write bus. Status bits are active-low: a 0 means pending. Reading a port acknowledges what that port reports.

The sub-processor handshake (halt, cancel, attention) does not reach its outputs at once. A three-state sequencer named `SY_IDLE`, `SY_WAIT` and `SY_APPLY` waits a fixed number of clocks and then copies the shadow values to the outputs. A trigger in any state goes to `SY_WAIT` and reloads the countdown (transition *arm*). `SY_WAIT` goes to `SY_APPLY` when the countdown reaches its last step (transition *expire*). `SY_APPLY` copies the shadow values and returns to `SY_IDLE` (transition *commit*). A free-running counter with a period set in clocks produces the timer source.

Top module: `irq_kbd_ctrl`

## Requirements
- R1: A read of offset 0 returns 0x7E with bit 7 = latched keycode bit 8 and bit 0 = the clock-fast flag. A write to offset 0 sets the flag from data bit 0 (1 = fast). The flag resets to parameter CLK_FAST_INIT (default 1) and drives `clk_fast_o`.
- R2: A write to offset 2 sets the enables: bit 0 keyboard, bit 1 printer, bit 2 timer, 1 = enabled. Other bits are ignored. All enables reset to 0. Clearing an enable drops that source's pending state.
- R3: A read of offset 3 returns {4'b1111, ~ext, ~timer, ~printer, ~keyboard}, where ext = `snd_irq_req` OR `mouse_irq_req`. Each bit is 0 while its source is pending.
- R4: A read of offset 3 clears the pending timer and printer sources. It leaves the keyboard source pending.
- R5: `kbd_strobe` latches the 9-bit keycode and makes the keyboard source pending when that source is enabled. A read of offset 1 returns keycode bits 7:0 and clears the keyboard pending state.
- R6: The printer source becomes pending on a rising edge of `prn_irq_req` while it is enabled.
- R7: The timer produces one event every TMR_PERIOD clocks. The event is recorded only while the timer is enabled.
- R8: `irq_o` is high exactly when a timer, keyboard or printer source is pending, or when `snd_irq_req` or `mouse_irq_req` is high.
- R9: A `sub_attn_req` pulse sets the attention flag. A read of offset 4 returns 0x7C with bit 7 = `sub_busy`, bit 1 = NOT `brk_key` and bit 0 = NOT attention, and then clears attention.
- R10: `firq_o` is the OR of `brk_key` and the delayed copy of attention.
- R11: A read of offset 5 returns bit 7 = `sub_busy`, bits 6:1 = 1 and bit 0 = `ext_det`. A write to offset 5 sets halt from bit 7 and cancel from bit 6.
- R12: A write to offset 5, or a change of attention, reaches `sub_halt_o`, `sub_cancel_o` and the attention part of `firq_o` exactly SYNC_DELAY (8) clocks later. A new trigger during the wait restarts the count.
- R13: After reset, `irq_o`, `firq_o`, `sub_halt_o` and `sub_cancel_o` are 0 and offset 3 reads 0xFF. Unmapped offsets read 0xFF. Writes to offsets 1, 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| kbd_strobe | input | 1 | New key code present |
| kbd_code | input | KEY_W | Key code |
| brk_key | input | 1 | Break key held |
| sub_attn_req | input | 1 | Attention pulse from sub-processor |
| sub_busy | input | 1 | Sub-processor busy |
| ext_det | input | 1 | External device detected |
| prn_irq_req | input | 1 | Printer request |
| snd_irq_req | input | 1 | Sound-chip request |
| mouse_irq_req | input | 1 | Pointer request |
| irq_o | output | 1 | Maskable interrupt |
| firq_o | output | 1 | Fast interrupt |
| sub_halt_o | output | 1 | Sub-processor halt |
| sub_cancel_o | output | 1 | Sub-processor cancel |
| clk_fast_o | output | 1 | Clock-fast flag |

## Verification
The hardest case to reach from the ports is the restart of the handshake delay. A second trigger must land while the sequencer is still in `SY_WAIT`, and the bench must tell the restarted commit apart from the commit the first trigger would have made. The bench writes to the sub-control offset and, four clocks later, writes a different value. It then checks that neither output moves at the clock where the first commit would have happened, and that both move together eight clocks after the second write. The timer is made observable by shortening TMR_PERIOD to 64 clocks, so both an enabled and a disabled window fit within a few hundred cycles.

// File: rtl/irq_kbd_pkg.sv
package irq_kbd_pkg;

    // Register offsets decoded on the CPU bus
    localparam int OFS_KEYHI  = 0;
    localparam int OFS_KEYLO  = 1;
    localparam int OFS_IRQEN  = 2;
    localparam int OFS_IRQST  = 3;
    localparam int OFS_FIRQST = 4;
    localparam int OFS_SUBCTL = 5;

    // Source indices in the enable and pending vectors (match enable bit positions)
    localparam int SRC_KBD = 0;
    localparam int SRC_PRN = 1;
    localparam int SRC_TMR = 2;
    localparam int NSRC    = 3;

    typedef enum logic [1:0] {
        SY_IDLE  = 2'd0,
        SY_WAIT  = 2'd1,
        SY_APPLY = 2'd2
    } sync_state_t;

    typedef struct packed {
        logic halt;
        logic cancel;
        logic attn;
    } sub_ctl_t;

endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int PERIOD = 101725
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_kbd_pkg::*;
#(
    parameter int KEY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic [NSRC-1:0]  en_wdata,
    input  logic             kbd_strobe,
    input  logic [KEY_W-1:0] kbd_code,
    input  logic             prn_req,
    input  logic             tmr_tick,
    input  logic             kbd_ack,
    input  logic             stat_ack,
    output logic [NSRC-1:0]  en_q,
    output logic [NSRC-1:0]  pend_q,
    output logic [KEY_W-1:0] key_q
);
    logic [NSRC-1:0] en_next;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic            prn_d_q;

    assign en_next = en_we ? en_wdata : en_q;

    always_comb begin
        set_vec          = '0;
        clr_vec          = '0;
        set_vec[SRC_KBD] = kbd_strobe;
        set_vec[SRC_PRN] = prn_req & ~prn_d_q;
        set_vec[SRC_TMR] = tmr_tick;
        clr_vec[SRC_KBD] = kbd_ack;
        clr_vec[SRC_PRN] = stat_ack;
        clr_vec[SRC_TMR] = stat_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            prn_d_q <= 1'b0;
            key_q   <= '0;
        end else begin
            en_q    <= en_next;
            prn_d_q <= prn_req;
            if (kbd_strobe) begin
                key_q <= kbd_code;
            end
        end
    end

    // One pending flag per source; a new event wins over an acknowledge
    for (genvar g = 0; g < NSRC; g++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else if (!en_next[g]) begin
                pend_q[g] <= 1'b0;
            end else if (set_vec[g] && en_q[g]) begin
                pend_q[g] <= 1'b1;
            end else if (clr_vec[g]) begin
                pend_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sub_sync_fsm.sv
module sub_sync_fsm
    import irq_kbd_pkg::*;
#(
    parameter int DELAY = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig,
    input  sub_ctl_t    shadow,
    output sub_ctl_t    applied_q,
    output sync_state_t state_o
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);
    localparam logic [CW-1:0] ONE    = CW'(1);

    sync_state_t   state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    assign state_o = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next state: arm, expire, commit
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            SY_IDLE: begin
                state_n = SY_IDLE;
            end
            SY_WAIT: begin
                if (cnt_q == ONE) begin
                    state_n = SY_APPLY;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            SY_APPLY: begin
                state_n = SY_IDLE;
            end
            default: begin
                state_n = SY_IDLE;
            end
        endcase
        if (trig) begin
            state_n = SY_WAIT;
            cnt_n   = RELOAD;
        end
    end

    // Outputs: copied from the shadow only in SY_APPLY
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            applied_q <= '0;
        end else if (state_q == SY_APPLY) begin
            applied_q <= shadow;
        end
    end
endmodule

// File: rtl/irq_kbd_ctrl.sv
module irq_kbd_ctrl
    import irq_kbd_pkg::*;
#(
    parameter int   ADDR_W        = 3,
    parameter int   KEY_W         = 9,
    parameter int   TMR_PERIOD    = 101725,
    parameter int   SYNC_DELAY    = 8,
    parameter logic CLK_FAST_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              kbd_strobe,
    input  logic [KEY_W-1:0]  kbd_code,
    input  logic              brk_key,
    input  logic              sub_attn_req,
    input  logic              sub_busy,
    input  logic              ext_det,
    input  logic              prn_irq_req,
    input  logic              snd_irq_req,
    input  logic              mouse_irq_req,
    output logic              irq_o,
    output logic              firq_o,
    output logic              sub_halt_o,
    output logic              sub_cancel_o,
    output logic              clk_fast_o
);
    localparam logic [ADDR_W-1:0] A_KEYHI  = ADDR_W'(OFS_KEYHI);
    localparam logic [ADDR_W-1:0] A_KEYLO  = ADDR_W'(OFS_KEYLO);
    localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(OFS_IRQEN);
    localparam logic [ADDR_W-1:0] A_IRQST  = ADDR_W'(OFS_IRQST);
    localparam logic [ADDR_W-1:0] A_FIRQST = ADDR_W'(OFS_FIRQST);
    localparam logic [ADDR_W-1:0] A_SUBCTL = ADDR_W'(OFS_SUBCTL);

    logic rd_en, wr_en;
    logic rd_keylo, rd_irqst, rd_firqst;
    logic wr_keyhi, wr_irqen, wr_subctl;

    logic [NSRC-1:0]  en_q;
    logic [NSRC-1:0]  pend_q;
    logic [KEY_W-1:0] key_q;
    logic             tmr_tick;
    logic             ext_any;

    logic        clk_fast_q;
    logic        halt_sh_q;
    logic        cancel_sh_q;
    logic        attn_q;
    logic        attn_n;
    logic        sync_trig;
    sub_ctl_t    shadow;
    sub_ctl_t    applied;
    sync_state_t sync_state;

    // Bus decode
    assign rd_en     = bus_sel & ~bus_wr;
    assign wr_en     = bus_sel & bus_wr;
    assign rd_keylo  = rd_en & (bus_addr == A_KEYLO);
    assign rd_irqst  = rd_en & (bus_addr == A_IRQST);
    assign rd_firqst = rd_en & (bus_addr == A_FIRQST);
    assign wr_keyhi  = wr_en & (bus_addr == A_KEYHI);
    assign wr_irqen  = wr_en & (bus_addr == A_IRQEN);
    assign wr_subctl = wr_en & (bus_addr == A_SUBCTL);

    irq_tick_gen #(
        .PERIOD (TMR_PERIOD)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tmr_tick)
    );

    irq_src_bank #(
        .KEY_W (KEY_W)
    ) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (wr_irqen),
        .en_wdata   (bus_wdata[NSRC-1:0]),
        .kbd_strobe (kbd_strobe),
        .kbd_code   (kbd_code),
        .prn_req    (prn_irq_req),
        .tmr_tick   (tmr_tick),
        .kbd_ack    (rd_keylo),
        .stat_ack   (rd_irqst),
        .en_q       (en_q),
        .pend_q     (pend_q),
        .key_q      (key_q)
    );

    // Attention flag: set by pulse (wins), cleared by read of offset 4
    always_comb begin
        attn_n = attn_q;
        if (rd_firqst) begin
            attn_n = 1'b0;
        end
        if (sub_attn_req) begin
            attn_n = 1'b1;
        end
    end

    assign sync_trig = wr_subctl | (attn_n != attn_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_fast_q  <= CLK_FAST_INIT;
            halt_sh_q   <= 1'b0;
            cancel_sh_q <= 1'b0;
            attn_q      <= 1'b0;
        end else begin
            attn_q <= attn_n;
            if (wr_keyhi) begin
                clk_fast_q <= bus_wdata[0];
            end
            if (wr_subctl) begin
                halt_sh_q   <= bus_wdata[7];
                cancel_sh_q <= bus_wdata[6];
            end
        end
    end

    always_comb begin
        shadow.halt   = halt_sh_q;
        shadow.cancel = cancel_sh_q;
        shadow.attn   = attn_q;
    end

    sub_sync_fsm #(
        .DELAY (SYNC_DELAY)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (sync_trig),
        .shadow    (shadow),
        .applied_q (applied),
        .state_o   (sync_state)
    );

    // Interrupt lines
    assign ext_any      = snd_irq_req | mouse_irq_req;
    assign irq_o        = (|pend_q) | ext_any;
    assign firq_o       = brk_key | applied.attn;
    assign sub_halt_o   = applied.halt;
    assign sub_cancel_o = applied.cancel;
    assign clk_fast_o   = clk_fast_q;

    // Read multiplexer
    always_comb begin
        bus_rdata = 8'hFF;
        case (bus_addr)
            A_KEYHI:  bus_rdata = {key_q[8], 6'b111111, clk_fast_q};
            A_KEYLO:  bus_rdata = key_q[7:0];
            A_IRQST:  bus_rdata = {4'hF, ~ext_any, ~pend_q[SRC_TMR],
                                   ~pend_q[SRC_PRN], ~pend_q[SRC_KBD]};
            A_FIRQST: bus_rdata = {sub_busy, 5'b11111, ~brk_key, ~attn_q};
            A_SUBCTL: bus_rdata = {sub_busy, 6'b111111, ext_det};
            default:  bus_rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/irq_kbd_chk.sv
module irq_kbd_chk
    import irq_kbd_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              kbd_strobe,
    input logic              sub_attn_req,
    input logic              tmr_tick,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   pend_q,
    input logic              attn_q,
    input sync_state_t       sync_state,
    input logic              sub_halt_o,
    input logic              sub_cancel_o
);
    logic rd_en, wr_en;
    assign rd_en = bus_sel & ~bus_wr;
    assign wr_en = bus_sel & bus_wr;

    a_r4_status_read_acks_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(OFS_IRQST) && !tmr_tick) |=> !pend_q[SRC_TMR]);

    a_r5_keylo_read_acks_kbd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(OFS_KEYLO) && !kbd_strobe) |=> !pend_q[SRC_KBD]);

    a_r2_disable_drops_kbd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFS_IRQEN) && !bus_wdata[SRC_KBD]) |=> !pend_q[SRC_KBD]);

    a_r7_timer_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[SRC_TMR] |-> !pend_q[SRC_TMR]);

    a_r9_attn_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(OFS_FIRQST) && !sub_attn_req) |=> !attn_q);

    a_r12_halt_moves_in_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sub_halt_o) |-> $past(sync_state == SY_APPLY));

    a_r12_cancel_moves_in_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sub_cancel_o) |-> $past(sync_state == SY_APPLY));
endmodule

bind irq_kbd_ctrl irq_kbd_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .kbd_strobe   (kbd_strobe),
    .sub_attn_req (sub_attn_req),
    .tmr_tick     (tmr_tick),
    .en_q         (en_q),
    .pend_q       (pend_q),
    .attn_q       (attn_q),
    .sync_state   (sync_state),
    .sub_halt_o   (sub_halt_o),
    .sub_cancel_o (sub_cancel_o)
);

// File: tb/test_irq_kbd_ctrl.sv
module test_irq_kbd_ctrl;
    localparam int P = 64;
    localparam int NVEC = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       kbd_strobe = 1'b0;
    logic [8:0] kbd_code = '0;
    logic       brk_key = 1'b0, sub_attn_req = 1'b0, sub_busy = 1'b0, ext_det = 1'b0;
    logic       prn_irq_req = 1'b0, snd_irq_req = 1'b0, mouse_irq_req = 1'b0;
    logic       irq_o, firq_o, sub_halt_o, sub_cancel_o, clk_fast_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;

    irq_kbd_ctrl #(
        .TMR_PERIOD (P),
        .SYNC_DELAY (8)
    ) i_irq_kbd_ctrl (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .kbd_strobe (kbd_strobe), .kbd_code (kbd_code),
        .brk_key (brk_key), .sub_attn_req (sub_attn_req), .sub_busy (sub_busy),
        .ext_det (ext_det), .prn_irq_req (prn_irq_req), .snd_irq_req (snd_irq_req),
        .mouse_irq_req (mouse_irq_req),
        .irq_o (irq_o), .firq_o (firq_o), .sub_halt_o (sub_halt_o),
        .sub_cancel_o (sub_cancel_o), .clk_fast_o (clk_fast_o)
    );

    // {wr, addr[2:0], wdata[7:0], expected[7:0]}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 3'd0, 8'h00, 8'h7F},   // R1 reset read, fast = 1
        {1'b1, 3'd0, 8'h00, 8'h00},   // R1 set slow
        {1'b0, 3'd0, 8'h00, 8'h7E},   // R1
        {1'b1, 3'd0, 8'h01, 8'h00},   // R1 set fast
        {1'b0, 3'd0, 8'h00, 8'h7F},   // R1
        {1'b0, 3'd3, 8'h00, 8'hFF},   // R3 nothing pending
        {1'b0, 3'd2, 8'h00, 8'hFF},   // R13 write-only offset
        {1'b0, 3'd4, 8'h00, 8'h7F},   // R9 idle attention port
        {1'b0, 3'd5, 8'h00, 8'h7E},   // R11 idle sub-control port
        {1'b1, 3'd3, 8'h00, 8'h00},   // R13 write to status ignored
        {1'b0, 3'd3, 8'h00, 8'hFF},   // R13
        {1'b0, 3'd6, 8'h00, 8'hFF}    // R13 unmapped
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #5 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic key_press(input logic [8:0] code);
        @(negedge clk);
        kbd_strobe = 1'b1; kbd_code = code;
        @(posedge clk);
        #1 kbd_strobe = 1'b0;
    endtask

    task automatic attn_pulse();
        @(negedge clk);
        sub_attn_req = 1'b1;
        @(posedge clk);
        #1 sub_attn_req = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 irq after reset", {7'b0, irq_o}, 8'h00);
        check("R13 firq after reset", {7'b0, firq_o}, 8'h00);
        check("R13 halt/cancel after reset", {6'b0, sub_halt_o, sub_cancel_o}, 8'h00);
        check("R1 clk_fast after reset", {7'b0, clk_fast_o}, 8'h01);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) begin
                bus_write(VEC[i][18:16], VEC[i][15:8]);
            end else begin
                bus_read(VEC[i][18:16], rd);
                check($sformatf("vector %0d (R1/R3/R9/R11/R13)", i), rd, VEC[i][7:0]);
            end
        end

        // R5 keyboard enabled
        bus_write(3'd2, 8'h01);
        key_press(9'h1A5);
        bus_read(3'd0, rd); check("R5 key bit8 at offset 0", rd, 8'hFF);
        bus_read(3'd3, rd); check("R5 keyboard pending", rd, 8'hFE);
        check("R8 irq from keyboard", {7'b0, irq_o}, 8'h01);
        bus_read(3'd3, rd); check("R4 status read keeps keyboard", rd, 8'hFE);
        bus_read(3'd1, rd); check("R5 key low byte", rd, 8'hA5);
        @(negedge clk);
        check("R5 irq cleared by key read", {7'b0, irq_o}, 8'h00);
        bus_read(3'd3, rd); check("R5 status after key read", rd, 8'hFF);

        // R2 disabled keyboard and disable clearing
        bus_write(3'd2, 8'h00);
        key_press(9'h03C);
        bus_read(3'd3, rd); check("R2 disabled keyboard not pending", rd, 8'hFF);
        bus_read(3'd1, rd); check("R5 code latched while disabled", rd, 8'h3C);
        bus_read(3'd0, rd); check("R1 bit7 follows key bit8", rd, 8'h7F);
        bus_write(3'd2, 8'h01);
        key_press(9'h011);
        bus_write(3'd2, 8'hF8);
        bus_read(3'd3, rd); check("R2 disable drops pending", rd, 8'hFF);
        check("R2 irq after disable", {7'b0, irq_o}, 8'h00);

        // R6 printer
        bus_write(3'd2, 8'h02);
        @(negedge clk) prn_irq_req = 1'b1;
        edges(1);
        bus_read(3'd3, rd); check("R6 printer pending", rd, 8'hFD);
        bus_read(3'd3, rd); check("R4 printer acked by status read", rd, 8'hFF);
        @(negedge clk) prn_irq_req = 1'b0;
        bus_write(3'd2, 8'h00);
        @(negedge clk) prn_irq_req = 1'b1;
        edges(2);
        bus_read(3'd3, rd); check("R6 disabled printer ignored", rd, 8'hFF);
        @(negedge clk) prn_irq_req = 1'b0;

        // R7 timer
        bus_write(3'd2, 8'h04);
        seen = 1'b0;
        for (int i = 0; i < 3 * P && !seen; i++) begin
            @(negedge clk);
            if (irq_o) seen = 1'b1;
        end
        check("R7 timer event seen", {7'b0, seen}, 8'h01);
        bus_read(3'd3, rd); check("R7 timer pending", rd, 8'hFB);
        bus_read(3'd3, rd); check("R4 timer acked by status read", rd, 8'hFF);
        bus_write(3'd2, 8'h00);
        seen = 1'b0;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (irq_o) seen = 1'b1;
        end
        check("R7 disabled timer silent", {7'b0, seen}, 8'h00);
        bus_read(3'd3, rd); check("R7 disabled timer status", rd, 8'hFF);

        // R8 external sources
        @(negedge clk) snd_irq_req = 1'b1;
        bus_read(3'd3, rd); check("R3 ext bit", rd, 8'hF7);
        check("R8 irq from sound", {7'b0, irq_o}, 8'h01);
        @(negedge clk) begin snd_irq_req = 1'b0; mouse_irq_req = 1'b1; end
        #1 check("R8 irq from mouse", {7'b0, irq_o}, 8'h01);
        @(negedge clk) mouse_irq_req = 1'b0;
        #1 check("R8 irq idle", {7'b0, irq_o}, 8'h00);

        // R9 R10 R12 attention
        attn_pulse();
        edges(7);
        check("R12 firq before delay", {7'b0, firq_o}, 8'h00);
        edges(1);
        check("R10 firq after delay", {7'b0, firq_o}, 8'h01);
        bus_read(3'd4, rd); check("R9 attention reads low", rd, 8'h7E);
        edges(7);
        check("R12 firq held during clear delay", {7'b0, firq_o}, 8'h01);
        edges(1);
        check("R12 firq cleared after delay", {7'b0, firq_o}, 8'h00);
        bus_read(3'd4, rd); check("R9 attention cleared by read", rd, 8'h7F);

        // R10 break key, R9/R11 busy and ext_det
        @(negedge clk) brk_key = 1'b1;
        #1 check("R10 firq from break", {7'b0, firq_o}, 8'h01);
        bus_read(3'd4, rd); check("R9 break bit", rd, 8'h7D);
        @(negedge clk) begin brk_key = 1'b0; sub_busy = 1'b1; end
        bus_read(3'd4, rd); check("R9 busy bit", rd, 8'hFF);
        bus_read(3'd5, rd); check("R11 busy bit", rd, 8'hFE);
        @(negedge clk) begin sub_busy = 1'b0; ext_det = 1'b1; end
        bus_read(3'd5, rd); check("R11 ext_det bit", rd, 8'h7F);
        @(negedge clk) ext_det = 1'b0;

        // R11 R12 halt and cancel
        bus_write(3'd5, 8'h80);
        edges(7);
        check("R12 halt before delay", {7'b0, sub_halt_o}, 8'h00);
        edges(1);
        check("R11 halt after delay", {7'b0, sub_halt_o}, 8'h01);
        bus_write(3'd5, 8'hC0);
        edges(4);
        bus_write(3'd5, 8'h40);
        edges(7);
        check("R12 restart holds outputs", {6'b0, sub_halt_o, sub_cancel_o}, 8'h02);
        edges(1);
        check("R12 restart commit", {6'b0, sub_halt_o, sub_cancel_o}, 8'h01);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule